// File: doc/BRIEF.md
# Single-Slot Posted Write and Delayed Read Tracker

This block sits on the target side of a bridge port and holds a single pending transaction. That transaction is either a posted write or a delayed read. The host side offers a simplified request: valid, direction, address, command and write data. Each request receives one registered response: accept, retry, or done with read data.

The local side performs the queued operation through a request/acknowledge handshake. The request is held until one acknowledge cycle arrives.

A posted write is accepted at once and then drained to the local side. A read first gets a retry while the block fetches the data locally. The data is returned only when the host issues the same read again after the local read has finished.

Any write that finds the slot occupied is dropped. Such a write raises a sticky error flag, which software clears by writing one to it. A level output shows while a posted write is still waiting.

Top module: `txn_slot_tracker`

## Requirements
- R1: After reset the response outputs (h_accept, h_retry, h_done), l_req, wr_pending and err_sticky are all low, and h_rdata is zero.
- R2: A write that finds the slot empty is answered with h_accept in the next cycle. From that cycle, wr_pending and l_req are high with l_is_read=0 and the latched address and data. Both fall in the cycle after the cycle in which l_ack is high.
- R3: A write that arrives while a posted write is queued is answered with h_accept. Its data is dropped, so the local side keeps the first address and data. err_sticky is high from the next cycle.
- R4: A read that arrives while a posted write is queued is answered with h_retry. It starts no local read.
- R5: A read that finds the slot empty is answered with h_retry. The block latches its address and command, and from the next cycle it raises l_req with l_is_read=1, l_addr and l_cmd set to those values.
- R6: Any read that arrives before l_ack has completed the local read is answered with h_retry. This holds for a repeat of the same read and for a read with another address. The local request stays unchanged.
- R7: After the local read has finished, a read with the same address and command is answered with h_done, and h_rdata carries the value given on l_rdata at the acknowledge. A read that differs in address or in command is answered with h_retry.
- R8: A write that arrives while a delayed read is pending or finished is answered with h_accept and dropped, and err_sticky is set. The delayed read still completes with its data.
- R9: err_clr high for a cycle clears err_sticky in the next cycle. If a dropped write occurs in the same cycle as err_clr, err_sticky stays high.
- R10: The slot is free in the cycle after h_done. A read issued then is treated as a new delayed read and is answered with h_retry and a new local read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host request present this cycle |
| h_is_read | input | 1 | 1 = read, 0 = write |
| h_addr | input | AW | Host address |
| h_cmd | input | CW | Host command code |
| h_wdata | input | DW | Host write data |
| err_clr | input | 1 | Write-one-to-clear strobe for err_sticky |
| h_accept | output | 1 | Write taken (registered, one cycle after request) |
| h_retry | output | 1 | Read must be retried (registered) |
| h_done | output | 1 | Read completed, h_rdata valid (registered) |
| h_rdata | output | DW | Read data returned with h_done |
| l_req | output | 1 | Local operation requested |
| l_is_read | output | 1 | Local operation is a read |
| l_addr | output | AW | Local operation address |
| l_cmd | output | CW | Local operation command |
| l_wdata | output | DW | Local write data |
| l_ack | input | 1 | Local side finished the operation this cycle |
| l_rdata | input | DW | Local read data, sampled with l_ack |
| wr_pending | output | 1 | A posted write is queued |
| err_sticky | output | 1 | A write was dropped since the last clear |

## Verification
Every host response, and every change to wr_pending, l_req and err_sticky, is registered. Each appears exactly one cycle after the edge that sampled the request, acknowledge or clear that caused it. The bench drives inputs on the falling edge and holds them across one rising edge. It samples all results on the following falling edge, which is the first point where the registered values are visible. Checks on unchanged local requests and dropped data are made in that same cycle and before the next stimulus.

// File: rtl/tts_pkg.sv
package tts_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_WR   = 2'd1,
      SLOT_RD   = 2'd2,
      SLOT_RDY  = 2'd3
   } slot_state_e;
endpackage

// File: rtl/tts_match.sv
module tts_match #(
   parameter int AW = 16,
   parameter int CW = 4
) (
   input  logic [AW-1:0] req_addr,
   input  logic [CW-1:0] req_cmd,
   input  logic [AW-1:0] held_addr,
   input  logic [CW-1:0] held_cmd,
   output logic          same
);
   localparam int KW = AW + CW;
   logic [KW-1:0] diff;

   assign diff = {req_addr, req_cmd} ^ {held_addr, held_cmd};

   generate
      if (KW <= 8) begin : g_flat
         assign same = (diff == '0);
      end else begin : g_split
         localparam int HALF = KW / 2;
         logic lo_eq, hi_eq;
         assign lo_eq = (diff[HALF-1:0] == '0);
         assign hi_eq = (diff[KW-1:HALF] == '0);
         assign same  = lo_eq & hi_eq;
      end
   endgenerate
endmodule

// File: rtl/tts_err_flag.sv
module tts_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R9
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/tts_slot_ctrl.sv
module tts_slot_ctrl
   import tts_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_valid,
   input  logic          h_is_read,
   input  logic [AW-1:0] h_addr,
   input  logic [CW-1:0] h_cmd,
   input  logic [DW-1:0] h_wdata,
   input  logic          hit,
   input  logic          l_ack,
   input  logic [DW-1:0] l_rdata,
   output logic          h_accept,
   output logic          h_retry,
   output logic          h_done,
   output logic [DW-1:0] h_rdata,
   output logic          l_req,
   output logic          l_is_read,
   output logic [AW-1:0] held_addr,
   output logic [CW-1:0] held_cmd,
   output logic [DW-1:0] held_wdata,
   output logic          drop_wr,
   output slot_state_e   state
);
   slot_state_e   state_n;
   logic          is_wr, is_rd, deliver;
   logic [DW-1:0] rd_buf;

   assign is_wr   = h_valid & ~h_is_read;
   assign is_rd   = h_valid &  h_is_read;
   assign drop_wr = is_wr & (state != SLOT_IDLE);
   assign deliver = is_rd & (state == SLOT_RDY) & hit;

   always_comb begin
      state_n = state;
      unique case (state)
         SLOT_IDLE: if (is_wr) state_n = SLOT_WR;
                    else if (is_rd) state_n = SLOT_RD;
         SLOT_WR:   if (l_ack) state_n = SLOT_IDLE;
         SLOT_RD:   if (l_ack) state_n = SLOT_RDY;
         SLOT_RDY:  if (deliver) state_n = SLOT_IDLE;
         default:   state_n = SLOT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SLOT_IDLE;
         held_addr  <= '0;
         held_cmd   <= '0;
         held_wdata <= '0;
         rd_buf     <= '0;
         h_accept   <= 1'b0;
         h_retry    <= 1'b0;
         h_done     <= 1'b0;
         h_rdata    <= '0;
      end else begin
         state    <= state_n;
         h_accept <= is_wr;
         h_retry  <= is_rd & ~deliver;
         h_done   <= deliver;
         h_rdata  <= deliver ? rd_buf : '0;
         if (state == SLOT_IDLE && h_valid) begin
            held_addr <= h_addr;
            held_cmd  <= h_cmd;
            if (is_wr) held_wdata <= h_wdata;
         end
         if (state == SLOT_RD && l_ack) rd_buf <= l_rdata;
      end
   end

   assign l_req     = (state == SLOT_WR) | (state == SLOT_RD);
   assign l_is_read = (state == SLOT_RD);

   // R2
   l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_req && !l_ack) |=> (l_req && $stable(held_addr) && $stable(held_wdata)));
   // R7
   deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deliver |=> (h_done && state == SLOT_IDLE));
   // R6
   early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && state == SLOT_RD) |=> (h_retry && !h_done));
   // R1
   resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({h_accept, h_retry, h_done}));
endmodule

// File: rtl/txn_slot_tracker.sv
module txn_slot_tracker
   import tts_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_valid,
   input  logic          h_is_read,
   input  logic [AW-1:0] h_addr,
   input  logic [CW-1:0] h_cmd,
   input  logic [DW-1:0] h_wdata,
   input  logic          err_clr,
   output logic          h_accept,
   output logic          h_retry,
   output logic          h_done,
   output logic [DW-1:0] h_rdata,
   output logic          l_req,
   output logic          l_is_read,
   output logic [AW-1:0] l_addr,
   output logic [CW-1:0] l_cmd,
   output logic [DW-1:0] l_wdata,
   input  logic          l_ack,
   input  logic [DW-1:0] l_rdata,
   output logic          wr_pending,
   output logic          err_sticky
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("txn_slot_tracker: AW must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("txn_slot_tracker: DW must be at least 1");
      end
      if (CW < 1) begin : g_bad_cw
         $error("txn_slot_tracker: CW must be at least 1");
      end
   endgenerate

   logic        hit, drop_wr;
   slot_state_e state;

   tts_match #(.AW(AW), .CW(CW)) u_match (
      .req_addr (h_addr),
      .req_cmd  (h_cmd),
      .held_addr(l_addr),
      .held_cmd (l_cmd),
      .same     (hit)
   );

   tts_slot_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_valid   (h_valid),
      .h_is_read (h_is_read),
      .h_addr    (h_addr),
      .h_cmd     (h_cmd),
      .h_wdata   (h_wdata),
      .hit       (hit),
      .l_ack     (l_ack),
      .l_rdata   (l_rdata),
      .h_accept  (h_accept),
      .h_retry   (h_retry),
      .h_done    (h_done),
      .h_rdata   (h_rdata),
      .l_req     (l_req),
      .l_is_read (l_is_read),
      .held_addr (l_addr),
      .held_cmd  (l_cmd),
      .held_wdata(l_wdata),
      .drop_wr   (drop_wr),
      .state     (state)
   );

   tts_err_flag u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (drop_wr),
      .clr_i (err_clr),
      .flag_o(err_sticky)
   );

   assign wr_pending = (state == SLOT_WR);

   // R3
   dup_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && !h_is_read && wr_pending) |=> (err_sticky && h_accept));
   // R4
   read_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && h_is_read && wr_pending && !l_ack) |=> (h_retry && !l_is_read));
   // R2
   pend_write_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pending |-> (l_req && !l_is_read));
endmodule

// File: tb/tb_txn_slot_tracker.sv
module tb_txn_slot_tracker;
   localparam int AW = 16, DW = 32, CW = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          h_valid = 0, h_is_read = 0, err_clr = 0, l_ack = 0;
   logic [AW-1:0] h_addr = '0;
   logic [CW-1:0] h_cmd = '0;
   logic [DW-1:0] h_wdata = '0, l_rdata = '0;
   logic          h_accept, h_retry, h_done, l_req, l_is_read, wr_pending, err_sticky;
   logic [DW-1:0] h_rdata, l_wdata;
   logic [AW-1:0] l_addr;
   logic [CW-1:0] l_cmd;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   txn_slot_tracker #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one host request for one rising edge; return at the next falling edge
   task automatic host(logic rd, logic [AW-1:0] a, logic [CW-1:0] c,
                       logic [DW-1:0] d, logic clr);
      h_valid = 1; h_is_read = rd; h_addr = a; h_cmd = c; h_wdata = d; err_clr = clr;
      @(negedge clk);
      h_valid = 0; err_clr = 0;
   endtask

   task automatic lack(logic [DW-1:0] d);
      l_ack = 1; l_rdata = d;
      @(negedge clk);
      l_ack = 0;
   endtask

   task automatic t_reset();
      chk("R1 resp", {h_accept, h_retry, h_done}, 0);
      chk("R1 l_req", l_req, 0);
      chk("R1 pend/err", {wr_pending, err_sticky}, 0);
      chk("R1 rdata", h_rdata, 0);
   endtask

   task automatic t_posted_write();
      host(0, 16'h0010, 4'h7, 32'hAAAA_0001, 0);
      chk("R2 accept", h_accept, 1);
      chk("R2 pending", wr_pending, 1);
      chk("R2 local", {l_req, l_is_read, l_addr, l_wdata}, {1'b1, 1'b0, 16'h0010, 32'hAAAA_0001});
      host(0, 16'h0044, 4'h7, 32'hBBBB_0002, 0);
      chk("R3 accept", h_accept, 1);
      chk("R3 err", err_sticky, 1);
      chk("R3 kept", {l_addr, l_wdata}, {16'h0010, 32'hAAAA_0001});
      host(1, 16'h0010, 4'h6, 0, 0);
      chk("R4 retry", {h_retry, h_done}, 2'b10);
      chk("R4 no read", {l_req, l_is_read}, 2'b10);
      lack(0);
      chk("R2 drained", {wr_pending, l_req}, 0);
   endtask

   task automatic t_err_clear();
      err_clr = 1; @(negedge clk); err_clr = 0;
      chk("R9 cleared", err_sticky, 0);
   endtask

   task automatic t_delayed_read();
      host(1, 16'h0020, 4'h6, 0, 0);
      chk("R5 retry", h_retry, 1);
      chk("R5 local", {l_req, l_is_read, l_addr, l_cmd}, {1'b1, 1'b1, 16'h0020, 4'h6});
      host(1, 16'h0020, 4'h6, 0, 0);
      chk("R6 same retry", {h_retry, h_done}, 2'b10);
      host(1, 16'h0024, 4'h6, 0, 0);
      chk("R6 other retry", {h_retry, h_done}, 2'b10);
      chk("R6 unchanged", {l_addr, l_cmd}, {16'h0020, 4'h6});
      host(0, 16'h0020, 4'h7, 32'h1234, 1);
      chk("R8 accept", h_accept, 1);
      chk("R9 set wins", err_sticky, 1);
      chk("R8 read kept", {l_req, l_is_read, l_addr}, {1'b1, 1'b1, 16'h0020});
      lack(32'hDEAD_BEEF);
      chk("R7 local done", l_req, 0);
      host(1, 16'h0020, 4'h5, 0, 0);
      chk("R7 cmd differs", {h_retry, h_done}, 2'b10);
      host(1, 16'h0022, 4'h6, 0, 0);
      chk("R7 addr differs", {h_retry, h_done}, 2'b10);
      host(0, 16'h0050, 4'h7, 32'h9, 0);
      chk("R8 write after fetch", {h_accept, err_sticky}, 2'b11);
      host(1, 16'h0020, 4'h6, 0, 0);
      chk("R7 done", {h_retry, h_done}, 2'b01);
      chk("R7 data", h_rdata, 32'hDEAD_BEEF);
      host(1, 16'h0030, 4'h2, 0, 0);
      chk("R10 new read retry", {h_retry, h_done}, 2'b10);
      chk("R10 new local", {l_req, l_is_read, l_addr, l_cmd}, {1'b1, 1'b1, 16'h0030, 4'h2});
      chk("R7 rdata zero", h_rdata, 0);
      lack(32'h0000_5A5A);
      host(1, 16'h0030, 4'h2, 0, 0);
      chk("R10 second done", {h_done, h_rdata}, {1'b1, 32'h0000_5A5A});
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            @(negedge clk);
            t_reset();
            t_posted_write();
            t_err_clear();
            t_delayed_read();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      disable fork;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule